// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the synchronous control front end of a pipelined burst SRAM, together with a small behavioural word array. On every clock it decides whether a new access starts, an open burst steps forward, the device stays suspended, or the device goes unselected. It then produces per-byte write strobes toward the array and returns read data through a registered output stage. Two start strobes are provided. One is meant for the processor and is gated by the primary chip enable. The other is meant for a cache controller and always starts a cycle.

A burst walks the low two address bits linearly, wrapping within an aligned group of four words. A read returns its first word on the third clock after the start and one word per clock after that. A write stores one word per clock. The tri-state drive enable follows the asynchronous output-enable input at once. A sleep input moves the block into a data-retaining standby, with fixed entry and recovery windows measured in clocks.

Top module: `pbsram_ctrl`

## Requirements
- R1: A clock with `strb_ctl_n` low always starts a cycle. A clock with only `strb_cpu_n` low starts one only when `ce_pri_n` is low; otherwise it is ignored and the open burst state, including its address and selection, is kept.
- R2: The selection is sampled only on a start clock and is "selected" exactly when `ce_pri_n`=0, `ce_hi`=1 and `ce_lo_n`=0. Chip-enable changes between starts have no effect.
- R3: After a start that samples "unselected", no array word is written and `rdata_oe_o` stays 0 until the next selected start.
- R4: A read started at clock edge k shows its first word on `rdata_o` with `rdata_oe_o`=1 after edge k+2. Each clock after the start with `adv_n`=0 yields the next word one edge later. The word address is the start address with its low two bits incremented modulo 4.
- R5: In a write burst, beat i is stored at edge k+1+i at the burst address of R4, using `wdata_i` present on that edge.
- R6: `gwr_n`=0 on a beat writes all four bytes, whatever `bwe_n` and `bsel_n` are.
- R7: With `gwr_n`=1 and `bwe_n`=0, only byte b (bits 8b+7..8b) with `bsel_n[b]`=0 is written. A beat with no byte selected, or with both `gwr_n` and `bwe_n` high, is a read.
- R8: On the first beat of a cycle started by `strb_cpu_n`, a write is performed only if `adv_n` is high on that clock. With `adv_n` low, the beat is a read.
- R9: With no start and `adv_n` high, no access happens and the burst position is held.
- R10: `rdata_oe_o` equals 1 only while `oe_n` is low and a read result sits in the output stage. It reacts to `oe_n` without waiting for a clock.
- R11: Raising `sleep_i` enters standby through a window of ceil(`SLEEP_NS`·1000/`CLK_PS`) clocks. Lowering it leaves standby through a window of the same length. No start or advance is accepted from the first clock `sleep_i` is high until recovery ends, and stored words are kept.
- R12: After synchronous reset, `rdata_oe_o` is 0 and the device is unselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, sampled on a start |
| strb_cpu_n | input | 1 | Processor start strobe, active low, gated by `ce_pri_n` |
| strb_ctl_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_pri_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Expansion chip enable, active high |
| ce_lo_n | input | 1 | Expansion chip enable, active low |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | BYTES | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Standby request, active high |
| wdata_i | input | BYTES*BYTE_W | Write data |
| rdata_o | output | BYTES*BYTE_W | Registered read data |
| rdata_oe_o | output | 1 | Drive enable for the read data tri-state |

## Verification
A selection flag that is stuck or sampled on the wrong clock shows up as a missing or unexpected drive enable on the third clock after a start. It also shows up as a write that lands while the chip enables said unselected. A burst counter that skips or fails to hold gives the wrong word on the second or later beat, and a suspend followed by a resume exposes that within two clocks. A mistake in the byte-mask or first-beat write gating corrupts single bytes, which the next read of that word reveals. A standby window of the wrong length lets a write through during entry or recovery, and the later read of that word shows it.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_ENTER = 2'd1,
    PWR_SLEEP = 2'd2,
    PWR_WAKE  = 2'd3
  } pwr_mode_t;

  // Clocks needed to cover a window of win_ns at a clock period of clk_ps.
  function automatic int unsigned win_cycles(input int unsigned win_ns,
                                             input int unsigned clk_ps);
    int unsigned c;
    c = (win_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/pbsram_pwr.sv
module pbsram_pwr #(
  parameter int unsigned WIN = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  output logic run_o
);
  import pbsram_pkg::*;

  localparam int CW = $clog2(WIN + 1);

  pwr_mode_t       mode_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PWR_RUN;
      cnt_q  <= '0;
    end else begin
      unique case (mode_q)
        PWR_RUN: begin
          if (sleep_i) begin
            mode_q <= PWR_ENTER;
            cnt_q  <= CW'(WIN - 1);
          end
        end
        PWR_ENTER: begin
          if (!sleep_i) begin
            mode_q <= PWR_WAKE;
            cnt_q  <= CW'(WIN - 1);
          end else if (cnt_q == '0) begin
            mode_q <= PWR_SLEEP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PWR_SLEEP: begin
          if (!sleep_i) begin
            mode_q <= PWR_WAKE;
            cnt_q  <= CW'(WIN - 1);
          end
        end
        PWR_WAKE: begin
          if (sleep_i) begin
            mode_q <= PWR_ENTER;
            cnt_q  <= CW'(WIN - 1);
          end else if (cnt_q == '0) begin
            mode_q <= PWR_RUN;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: mode_q <= PWR_RUN;
      endcase
    end
  end

  assign run_o = (mode_q == PWR_RUN) && !sleep_i;

endmodule

// File: rtl/pbsram_seq.sv
module pbsram_seq #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              ce_pri_n,
  input  logic              ce_hi,
  input  logic              ce_lo_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              start_o,
  output logic              sel_o,
  output logic              acc_o,
  output logic              first_cpu_o,
  output logic [ADDR_W-1:0] beat_addr_o
);
  logic               cpu_org;
  logic               ce_ok;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               sel_q, acc_q, fcpu_q;

  assign cpu_org = !strb_cpu_n && !ce_pri_n;
  assign start_o = run_i && (!strb_ctl_n || cpu_org);
  assign ce_ok   = !ce_pri_n && ce_hi && !ce_lo_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      acc_q  <= 1'b0;
      fcpu_q <= 1'b0;
    end else if (start_o) begin
      base_q <= addr_i;
      cnt_q  <= '0;
      sel_q  <= ce_ok;
      acc_q  <= ce_ok;
      fcpu_q <= cpu_org;
    end else if (run_i && sel_q && !adv_n) begin
      cnt_q  <= cnt_q + 1'b1;
      acc_q  <= 1'b1;
      fcpu_q <= 1'b0;
    end else begin
      acc_q  <= 1'b0;
      fcpu_q <= 1'b0;
    end
  end

  assign beat_addr_o = {base_q[ADDR_W-1:BURST_W], base_q[BURST_W-1:0] + cnt_q};
  assign sel_o       = sel_q;
  assign acc_o       = acc_q;
  assign first_cpu_o = fcpu_q;

endmodule

// File: rtl/pbsram_wrmask.sv
module pbsram_wrmask #(
  parameter int BYTES = 4
) (
  input  logic             acc_i,
  input  logic             first_cpu_i,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwe_n,
  input  logic [BYTES-1:0] bsel_n,
  output logic [BYTES-1:0] be_o,
  output logic             rd_o
);
  logic             blocked;
  logic [BYTES-1:0] raw;

  assign blocked = first_cpu_i && !adv_n;

  always_comb begin
    if (!gwr_n)      raw = {BYTES{1'b1}};
    else if (!bwe_n) raw = ~bsel_n;
    else             raw = '0;
  end

  assign be_o = (acc_i && !blocked) ? raw : '0;
  assign rd_o = acc_i && (be_o == '0);

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic [BYTES-1:0]        we_i,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  output logic [BYTES*BYTE_W-1:0] q_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i[b]) mem[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
      if (rd_i)    q_o[b*BYTE_W +: BYTE_W] <= mem[addr_i];
    end
  end

endmodule

// File: rtl/pbsram_outreg.sv
module pbsram_outreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic [DW-1:0] q_i,
  input  logic          oe_n,
  output logic [DW-1:0] rdata_o,
  output logic          vld_o,
  output logic          oe_o
);
  logic          vld_q;
  logic [DW-1:0] dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) dout_q <= q_i;
    end
  end

  assign rdata_o = dout_q;
  assign vld_o   = vld_q;
  assign oe_o    = vld_q && !oe_n;

endmodule

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl #(
  parameter int          ADDR_W   = 8,
  parameter int          BYTES    = 4,
  parameter int          BYTE_W   = 8,
  parameter int          BURST_W  = 2,
  parameter int unsigned CLK_PS   = 8000,
  parameter int unsigned SLEEP_NS = 100
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic                    ce_pri_n,
  input  logic                    ce_hi,
  input  logic                    ce_lo_n,
  input  logic                    gwr_n,
  input  logic                    bwe_n,
  input  logic [BYTES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic                    sleep_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  localparam int          DW  = BYTES * BYTE_W;
  localparam int unsigned WIN = pbsram_pkg::win_cycles(SLEEP_NS, CLK_PS);

  logic              run_w, start_w, sel_w, acc_w, fcpu_w, rd_w, rd1_q, ovld_w;
  logic [ADDR_W-1:0] baddr_w;
  logic [BYTES-1:0]  be_w;
  logic [DW-1:0]     q_w;

  pbsram_pwr #(.WIN(WIN)) pwr_i (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .run_o(run_w)
  );

  pbsram_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) seq_i (
    .clk(clk), .rst(rst), .run_i(run_w),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .ce_pri_n(ce_pri_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n), .addr_i(addr_i),
    .start_o(start_w), .sel_o(sel_w), .acc_o(acc_w),
    .first_cpu_o(fcpu_w), .beat_addr_o(baddr_w)
  );

  pbsram_wrmask #(.BYTES(BYTES)) wm_i (
    .acc_i(acc_w), .first_cpu_i(fcpu_w), .adv_n(adv_n),
    .gwr_n(gwr_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .be_o(be_w), .rd_o(rd_w)
  );

  pbsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) arr_i (
    .clk(clk), .we_i(be_w), .rd_i(rd_w), .addr_i(baddr_w),
    .wdata_i(wdata_i), .q_o(q_w)
  );

  always_ff @(posedge clk) begin
    if (rst) rd1_q <= 1'b0;
    else     rd1_q <= rd_w;
  end

  pbsram_outreg #(.DW(DW)) out_i (
    .clk(clk), .rst(rst), .vld_i(rd1_q), .q_i(q_w), .oe_n(oe_n),
    .rdata_o(rdata_o), .vld_o(ovld_w), .oe_o(rdata_oe_o)
  );

endmodule

// File: rtl/pbsram_ctrl_chk.sv
module pbsram_ctrl_chk #(
  parameter int BYTES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             oe_n,
  input logic             gwr_n,
  input logic             adv_n,
  input logic             rdata_oe_o,
  input logic             run,
  input logic             start,
  input logic             sel,
  input logic             acc,
  input logic             fcpu,
  input logic [BYTES-1:0] be,
  input logic             rd,
  input logic             ovld
);

  AST_CE_HELD: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(sel));                                    // R2

  AST_RD_PIPE: assert property (@(posedge clk) disable iff (rst)
    rd |-> ##2 ovld);                                            // R4

  AST_BE_IN_BEAT: assert property (@(posedge clk) disable iff (rst)
    (|be) |-> acc);                                              // R5

  AST_GW_ALL: assert property (@(posedge clk) disable iff (rst)
    (acc && !gwr_n && !(fcpu && !adv_n)) |-> (&be));             // R6

  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
    rdata_oe_o |-> !oe_n);                                       // R10

  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> !acc);                                              // R11

endmodule

bind pbsram_ctrl pbsram_ctrl_chk #(.BYTES(BYTES)) chk_i (
  .clk(clk), .rst(rst), .oe_n(oe_n), .gwr_n(gwr_n), .adv_n(adv_n),
  .rdata_oe_o(rdata_oe_o), .run(run_w), .start(start_w), .sel(sel_w),
  .acc(acc_w), .fcpu(fcpu_w), .be(be_w), .rd(rd_w), .ovld(ovld_w)
);

// File: tb/pbsram_ctrl_tb_top.sv
module pbsram_ctrl_tb_top;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
  logic          ce_pri_n = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0;
  logic          gwr_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    bsel_n = 4'hF;
  logic          oe_n = 1'b0, sleep_i = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rdata_oe;

  logic [31:0]   mdl [DEPTH];
  int            n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  pbsram_ctrl dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .ce_pri_n(ce_pri_n),
    .ce_hi(ce_hi), .ce_lo_n(ce_lo_n), .gwr_n(gwr_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .oe_n(oe_n), .sleep_i(sleep_i), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int burst_addr(input int a, input int i);
    return (a & ~3) | ((a + i) & 3);
  endfunction

  task automatic ce_good();
    ce_pri_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
  endtask

  task automatic wr_burst(input bit cpu, input int a, input int n, input bit gw,
                          input bit bwe, input logic [3:0] bs, input bit upd);
    logic [3:0] be;
    be = gw ? 4'hF : (bwe ? ~bs : 4'h0);
    @(negedge clk);
    addr = AW'(a); ce_good();
    if (cpu) strb_cpu_n = 1'b0; else strb_ctl_n = 1'b0;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      int ba;
      @(negedge clk);
      strb_cpu_n = 1'b1; strb_ctl_n = 1'b1;
      d = $urandom; wdata = d;
      gwr_n = !gw; bwe_n = !bwe; bsel_n = bs;
      adv_n = (i < n - 1) ? 1'b0 : 1'b1;
      ba = burst_addr(a, i);
      if (upd)
        for (int b = 0; b < 4; b++)
          if (be[b]) mdl[ba][8*b +: 8] = d[8*b +: 8];
      @(posedge clk);
    end
    @(negedge clk);
    gwr_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF; adv_n = 1'b1;
  endtask

  task automatic rd_burst(input bit cpu, input int a, input int n, input string tag);
    @(negedge clk);
    addr = AW'(a); ce_good(); gwr_n = 1'b1; bwe_n = 1'b1;
    if (cpu) strb_cpu_n = 1'b0; else strb_ctl_n = 1'b0;
    @(posedge clk);
    for (int m = 1; m <= n + 2; m++) begin
      @(negedge clk);
      if (m >= 3) begin
        int ba;
        ba = burst_addr(a, m - 3);
        chk(rdata_oe === 1'b1 && rdata === mdl[ba], tag, rdata, mdl[ba]);
      end
      strb_cpu_n = 1'b1; strb_ctl_n = 1'b1;
      adv_n = (m < n) ? 1'b0 : 1'b1;
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(rdata_oe === 1'b0, "R12 reset drive", {31'd0, rdata_oe}, 32'd0);

    // fill every word with full-word burst writes
    for (int a = 0; a < DEPTH; a += 4) wr_burst(0, a, 4, 1, 0, 4'hF, 1);

    // R4 wrapping read burst from the third word of a group
    rd_burst(0, 8'h12, 4, "R4 wrap read");
    // R5 controller burst write then read back
    wr_burst(0, 8'h31, 4, 1, 0, 4'hF, 1);
    rd_burst(0, 8'h30, 4, "R5 burst write");
    // R6 global write ignores byte selects
    wr_burst(0, 8'h44, 1, 1, 1, 4'hF, 1);
    rd_burst(0, 8'h44, 1, "R6 global write");
    // R7 byte-masked write of bytes 0 and 2
    wr_burst(0, 8'h45, 1, 0, 1, 4'b1010, 1);
    rd_burst(1, 8'h45, 1, "R7 byte mask");
    // R7 byte enable with no byte selected is a read
    wr_burst(0, 8'h46, 1, 0, 1, 4'hF, 1);
    rd_burst(0, 8'h46, 1, "R7 no byte");
    // R8 processor write with advance high lands
    wr_burst(1, 8'h50, 1, 1, 0, 4'hF, 1);
    rd_burst(0, 8'h50, 1, "R8 cpu write");

    // R8 processor first beat with advance low is a read
    @(negedge clk);
    addr = 8'h54; ce_good(); strb_cpu_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    strb_cpu_n = 1'b1; gwr_n = 1'b0; wdata = 32'hDEAD_0001; adv_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    gwr_n = 1'b1; adv_n = 1'b1;
    repeat (2) @(posedge clk);
    rd_burst(0, 8'h54, 1, "R8 blocked write");

    // R1 R2 R9: ignored processor start, held selection, resumed burst
    @(negedge clk);
    addr = 8'h20; ce_good(); strb_ctl_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    strb_ctl_n = 1'b1; adv_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    strb_cpu_n = 1'b0; ce_pri_n = 1'b1; addr = 8'h77;
    @(posedge clk);
    @(negedge clk);
    strb_cpu_n = 1'b1; ce_hi = 1'b0; adv_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    adv_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(rdata_oe === 1'b1 && rdata === mdl[8'h21], "R1 R2 R9 resume", rdata, mdl[8'h21]);
    ce_good();

    // R3 deselected start: no drive and no write
    @(negedge clk);
    addr = 8'h60; ce_hi = 1'b0; strb_ctl_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    strb_ctl_n = 1'b1; ce_good(); gwr_n = 1'b0; wdata = 32'hBAD0_BAD0; adv_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(rdata_oe === 1'b0, "R3 unselected drive", {31'd0, rdata_oe}, 32'd0);
    end
    gwr_n = 1'b1; adv_n = 1'b1;
    rd_burst(0, 8'h60, 4, "R3 unselected write");

    // R10 asynchronous output enable
    @(negedge clk);
    addr = 8'h70; strb_ctl_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    strb_ctl_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(rdata_oe === 1'b1 && rdata === mdl[8'h70], "R10 drive on", rdata, mdl[8'h70]);
    oe_n = 1'b1;
    #1 chk(rdata_oe === 1'b0, "R10 oe off", {31'd0, rdata_oe}, 32'd0);
    oe_n = 1'b0;
    #1 chk(rdata_oe === 1'b1, "R10 oe on", {31'd0, rdata_oe}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk(rdata_oe === 1'b0, "R10 no result", {31'd0, rdata_oe}, 32'd0);

    // R11 standby: writes refused during entry, sleep and recovery
    wr_burst(0, 8'h80, 1, 1, 0, 4'hF, 1);
    @(negedge clk);
    sleep_i = 1'b1;
    repeat (2) @(posedge clk);
    wr_burst(0, 8'h80, 1, 1, 0, 4'hF, 0);
    repeat (20) @(posedge clk);
    wr_burst(1, 8'h80, 1, 1, 0, 4'hF, 0);
    @(negedge clk);
    sleep_i = 1'b0;
    @(posedge clk);
    wr_burst(0, 8'h80, 1, 1, 0, 4'hF, 0);
    repeat (16) @(posedge clk);
    rd_burst(0, 8'h80, 1, "R11 retention");
    wr_burst(0, 8'h81, 1, 1, 0, 4'hF, 1);
    rd_burst(0, 8'h81, 1, "R11 resume");

    // constrained random mix (R4 R5 R6 R7 R8)
    for (int it = 0; it < 80; it++) begin
      int a, n, k;
      bit cpu;
      a = $urandom % DEPTH; n = 1 + ($urandom % 4); cpu = $urandom % 2;
      k = $urandom % 3;
      if ($urandom % 2) begin
        if (cpu) n = 1;
        wr_burst(cpu, a, n, k == 0, k == 1, 4'($urandom), 1);
      end else begin
        rd_burst(cpu, a, n, "R4 random read");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule